// File: doc/BRIEF.md
# USB Endpoint Data Toggle Tracker

This block keeps the DATA0/DATA1 sequence state of one USB device endpoint. The packet receiver tells it when a data packet has ended, whether that packet was accepted (good CRC, room to store it) and which data PID it carried. From that and the endpoint's transfer type, the block keeps a toggle bit, shows the PID it expects next, and pulses an error flag when an accepted packet carries the wrong PID. The packet is then treated as a retransmission and the toggle state is left unchanged.

Control endpoints follow their own stage rules. A SETUP token forces the next expected packet to DATA0. The data stage then alternates as on a bulk endpoint. While the status stage is signalled, DATA1 is expected. Isochronous endpoints never check the sequence. Software pulses the endpoint clear input after it clears a halt condition, and that pulse starts the sequence again from DATA0.

Top module: `toggle_tracker`

## Requirements
- R1: Reset is synchronous and active high. After reset, tgl_o is 0, seq_err_o is 0 and exp_pid_o shows DATA0.
- R2: PID codes are DATA0 = 4'b0011 and DATA1 = 4'b1011. An accepted DATA0 on a non-isochronous endpoint, when DATA0 is expected, sets tgl_o at the next clock edge, and DATA1 is then expected.
- R3: An accepted DATA1, when DATA1 is expected, clears tgl_o at the next clock edge.
- R4: A packet end with rx_good_i low changes neither tgl_o nor seq_err_o.
- R5: An accepted data PID on a non-isochronous endpoint that differs from exp_pid_o raises seq_err_o for one cycle, starting at the next edge, and leaves tgl_o unchanged.
- R6: ep_clr_i clears the toggle and any pending SETUP state at the next edge. It takes priority over a packet in the same cycle, and that packet raises no error.
- R7: Endpoint type codes are 00 control, 01 isochronous, 10 bulk, 11 interrupt. On a control endpoint, setup_tok_i clears the toggle and forces exp_pid_o to DATA0 until the next accepted data packet that is not in error.
- R8: On a control endpoint with status_stage_i high and no SETUP pending, exp_pid_o is DATA1. A pending SETUP takes precedence over the status stage.
- R9: On an isochronous endpoint, seq_err_o is never raised. The toggle still follows each accepted data PID (set after DATA0, cleared after DATA1).
- R10: An accepted packet whose PID is neither DATA0 nor DATA1 changes nothing, and exp_pid_o only ever shows DATA0 or DATA1.
- R11: setup_tok_i and status_stage_i have no effect on non-control endpoints.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_end_i | input | 1 | One-cycle strobe at the end of a received data packet |
| rx_good_i | input | 1 | Packet was accepted (valid with rx_end_i) |
| rx_pid_i | input | 4 | PID field of the received packet |
| setup_tok_i | input | 1 | One-cycle strobe: SETUP token addressed to this endpoint |
| ep_kind_i | input | 2 | Endpoint transfer type |
| ep_clr_i | input | 1 | One-cycle endpoint reset strobe |
| status_stage_i | input | 1 | Control transfer is in its status stage |
| tgl_o | output | 1 | Toggle bit |
| exp_pid_o | output | 4 | PID expected for the next data packet |
| seq_err_o | output | 1 | Sequence mismatch pulse |

## Verification
The hardest case to reach is an error that occurs while a SETUP is still pending, because it needs a control endpoint, a SETUP strobe and then an accepted DATA1 in a state where the toggle alone would expect DATA0. The stimulus therefore sets the toggle first, issues the SETUP and sends DATA1. It then checks that the error appears and that DATA0 is still expected afterwards. Collisions are driven in single cycles: an endpoint clear arriving with a packet end, and a SETUP arriving during the status stage. These show which rule wins.

// File: rtl/toggle_pkg.sv
package toggle_pkg;

    localparam int PID_W = 4;
    typedef logic [PID_W-1:0] pid_t;

    localparam pid_t PID_DATA0 = 4'b0011;
    localparam pid_t PID_DATA1 = 4'b1011;

    typedef enum logic [1:0] {
        EP_CTRL = 2'b00,
        EP_ISO  = 2'b01,
        EP_BULK = 2'b10,
        EP_INTR = 2'b11
    } ep_kind_e;

    typedef struct packed {
        logic is_data;
        logic is_one;
    } pid_class_t;

    typedef struct packed {
        logic clr;
        logic arm;
        logic load;
        logic load_val;
        logic err;
    } tgl_action_t;

    function automatic pid_class_t classify_pid(pid_t p);
        pid_class_t c;
        c.is_data = (p == PID_DATA0) || (p == PID_DATA1);
        c.is_one  = (p == PID_DATA1);
        return c;
    endfunction

    function automatic pid_t pid_of(logic one);
        return one ? PID_DATA1 : PID_DATA0;
    endfunction

endpackage

// File: rtl/tgl_pid_decode.sv
module tgl_pid_decode
    import toggle_pkg::*;
(
    input  pid_t       pid_i,
    output pid_class_t cls_o
);
    always_comb begin
        cls_o = classify_pid(pid_i);
    end
endmodule

// File: rtl/tgl_expect.sv
module tgl_expect
    import toggle_pkg::*;
(
    input  logic     tgl_i,
    input  logic     setup_pend_i,
    input  ep_kind_e kind_i,
    input  logic     status_i,
    output logic     exp_one_o,
    output pid_t     exp_pid_o
);
    always_comb begin
        if (setup_pend_i)
            exp_one_o = 1'b0;
        else if (kind_i == EP_CTRL && status_i)
            exp_one_o = 1'b1;
        else
            exp_one_o = tgl_i;
        exp_pid_o = pid_of(exp_one_o);
    end
endmodule

// File: rtl/tgl_arbiter.sv
module tgl_arbiter
    import toggle_pkg::*;
(
    input  logic        ep_clr_i,
    input  logic        setup_tok_i,
    input  ep_kind_e    kind_i,
    input  logic        rx_end_i,
    input  logic        rx_good_i,
    input  pid_class_t  cls_i,
    input  logic        exp_one_i,
    output tgl_action_t act_o
);
    logic is_ctrl;
    logic pkt_take;

    always_comb begin
        is_ctrl  = (kind_i == EP_CTRL);
        pkt_take = rx_end_i && rx_good_i && cls_i.is_data;
        act_o    = '0;
        if (ep_clr_i) begin
            act_o.clr = 1'b1;
        end else if (setup_tok_i && is_ctrl) begin
            act_o.arm = 1'b1;
        end else if (pkt_take) begin
            if (kind_i == EP_ISO || cls_i.is_one == exp_one_i) begin
                act_o.load     = 1'b1;
                act_o.load_val = ~cls_i.is_one;
            end else begin
                act_o.err = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tgl_state.sv
module tgl_state
    import toggle_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  tgl_action_t act_i,
    output logic        tgl_o,
    output logic        setup_pend_o,
    output logic        err_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tgl_o        <= 1'b0;
            setup_pend_o <= 1'b0;
            err_o        <= 1'b0;
        end else begin
            err_o <= act_i.err;
            if (act_i.clr) begin
                tgl_o        <= 1'b0;
                setup_pend_o <= 1'b0;
            end else if (act_i.arm) begin
                tgl_o        <= 1'b0;
                setup_pend_o <= 1'b1;
            end else if (act_i.load) begin
                tgl_o        <= act_i.load_val;
                setup_pend_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/toggle_tracker.sv
module toggle_tracker
    import toggle_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_end_i,
    input  logic       rx_good_i,
    input  logic [3:0] rx_pid_i,
    input  logic       setup_tok_i,
    input  logic [1:0] ep_kind_i,
    input  logic       ep_clr_i,
    input  logic       status_stage_i,
    output logic       tgl_o,
    output logic [3:0] exp_pid_o,
    output logic       seq_err_o
);
    ep_kind_e    kind;
    pid_class_t  cls;
    tgl_action_t act;
    logic        exp_one;
    logic        setup_pend;
    pid_t        exp_pid;

    assign kind      = ep_kind_e'(ep_kind_i);
    assign exp_pid_o = exp_pid;

    tgl_pid_decode u_dec (
        .pid_i (rx_pid_i),
        .cls_o (cls)
    );

    tgl_expect u_exp (
        .tgl_i        (tgl_o),
        .setup_pend_i (setup_pend),
        .kind_i       (kind),
        .status_i     (status_stage_i),
        .exp_one_o    (exp_one),
        .exp_pid_o    (exp_pid)
    );

    tgl_arbiter u_arb (
        .ep_clr_i    (ep_clr_i),
        .setup_tok_i (setup_tok_i),
        .kind_i      (kind),
        .rx_end_i    (rx_end_i),
        .rx_good_i   (rx_good_i),
        .cls_i       (cls),
        .exp_one_i   (exp_one),
        .act_o       (act)
    );

    tgl_state u_st (
        .clk          (clk),
        .rst          (rst),
        .act_i        (act),
        .tgl_o        (tgl_o),
        .setup_pend_o (setup_pend),
        .err_o        (seq_err_o)
    );
endmodule

// File: rtl/toggle_tracker_chk.sv
module toggle_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_end_i,
    input logic       rx_good_i,
    input logic       setup_tok_i,
    input logic [1:0] ep_kind_i,
    input logic       ep_clr_i,
    input logic       status_stage_i,
    input logic       tgl_o,
    input logic [3:0] exp_pid_o,
    input logic       seq_err_o,
    input logic       setup_pend
);
    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rx_end_i && !rx_good_i && !ep_clr_i && !setup_tok_i) |=> ($stable(tgl_o) && !seq_err_o)); // R4

    AST_ERR_KEEPS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        seq_err_o |-> (tgl_o == $past(tgl_o) && $past(rx_end_i && rx_good_i))); // R5

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        ep_clr_i |=> (!tgl_o && !seq_err_o)); // R6

    AST_SETUP_DATA0: assert property (@(posedge clk) disable iff (rst)
        (setup_tok_i && ep_kind_i == 2'b00 && !ep_clr_i) |=> (exp_pid_o == 4'b0011 && !tgl_o)); // R7

    AST_STATUS_DATA1: assert property (@(posedge clk) disable iff (rst)
        (ep_kind_i == 2'b00 && status_stage_i && !setup_pend) |-> exp_pid_o == 4'b1011); // R8

    AST_ISO_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (rx_end_i && ep_kind_i == 2'b01) |=> !seq_err_o); // R9

    AST_EXP_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (exp_pid_o == 4'b0011 || exp_pid_o == 4'b1011)); // R10
endmodule

bind toggle_tracker toggle_tracker_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .rx_end_i       (rx_end_i),
    .rx_good_i      (rx_good_i),
    .setup_tok_i    (setup_tok_i),
    .ep_kind_i      (ep_kind_i),
    .ep_clr_i       (ep_clr_i),
    .status_stage_i (status_stage_i),
    .tgl_o          (tgl_o),
    .exp_pid_o      (exp_pid_o),
    .seq_err_o      (seq_err_o),
    .setup_pend     (setup_pend)
);

// File: tb/toggle_tracker_tb.sv
module toggle_tracker_tb;

    localparam logic [3:0] D0 = 4'b0011;
    localparam logic [3:0] D1 = 4'b1011;
    localparam logic [1:0] K_CTRL = 2'b00;
    localparam logic [1:0] K_ISO  = 2'b01;
    localparam logic [1:0] K_BULK = 2'b10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_end = 1'b0;
    logic       rx_good = 1'b0;
    logic [3:0] rx_pid = 4'b0000;
    logic       setup_tok = 1'b0;
    logic [1:0] ep_kind = K_BULK;
    logic       ep_clr = 1'b0;
    logic       status_stage = 1'b0;
    logic       tgl;
    logic [3:0] exp_pid;
    logic       seq_err;

    always #2 clk = ~clk;

    toggle_tracker u_dut (
        .clk            (clk),
        .rst            (rst),
        .rx_end_i       (rx_end),
        .rx_good_i      (rx_good),
        .rx_pid_i       (rx_pid),
        .setup_tok_i    (setup_tok),
        .ep_kind_i      (ep_kind),
        .ep_clr_i       (ep_clr),
        .status_stage_i (status_stage),
        .tgl_o          (tgl),
        .exp_pid_o      (exp_pid),
        .seq_err_o      (seq_err)
    );

    typedef struct {
        logic       tgl;
        logic [3:0] pid;
        logic       err;
        string      tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic m_tgl = 1'b0;
    logic m_pend = 1'b0;

    function automatic logic model_exp(logic [1:0] k, logic st);
        if (m_pend) return 1'b0;
        if (k == K_CTRL && st) return 1'b1;
        return m_tgl;
    endfunction

    task automatic step(input logic r, input logic e, input logic g, input logic [3:0] p,
                        input logic s, input logic [1:0] k, input logic c, input logic st,
                        input string tag);
        exp_item_t it;
        logic err;
        logic one;
        @(negedge clk);
        rst = r; rx_end = e; rx_good = g; rx_pid = p;
        setup_tok = s; ep_kind = k; ep_clr = c; status_stage = st;
        err = 1'b0;
        if (r || c) begin
            m_tgl = 1'b0; m_pend = 1'b0;
        end else if (s && k == K_CTRL) begin
            m_tgl = 1'b0; m_pend = 1'b1;
        end else if (e && g && (p == D0 || p == D1)) begin
            one = (p == D1);
            if (k == K_ISO || one == model_exp(k, st)) begin
                m_tgl = ~one; m_pend = 1'b0;
            end else begin
                err = 1'b1;
            end
        end
        it.tgl = m_tgl;
        it.pid = model_exp(k, st) ? D1 : D0;
        it.err = err;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (tgl !== it.tgl || exp_pid !== it.pid || seq_err !== it.err) begin
                failures++;
                $display("FAIL %s actual tgl=%0b pid=%b err=%0b expected tgl=%0b pid=%b err=%0b",
                         it.tag, tgl, exp_pid, seq_err, it.tgl, it.pid, it.err);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(1, 0, 0, 4'h0, 0, K_BULK, 0, 0, "R1");
        step(1, 0, 0, 4'h0, 0, K_BULK, 0, 0, "R1");
        step(0, 0, 0, 4'h0, 0, K_BULK, 0, 0, "R1");
        // R2 / R3 bulk alternation
        step(0, 1, 1, D0, 0, K_BULK, 0, 0, "R2");
        step(0, 1, 1, D1, 0, K_BULK, 0, 0, "R3");
        step(0, 1, 1, D0, 0, K_BULK, 0, 0, "R2");
        step(0, 1, 1, D1, 0, K_BULK, 0, 0, "R3");
        // R4 rejected packet
        step(0, 1, 0, D0, 0, K_BULK, 0, 0, "R4");
        step(0, 1, 0, D1, 0, K_BULK, 0, 0, "R4");
        // R5 mismatch pulse then drop
        step(0, 1, 1, D1, 0, K_BULK, 0, 0, "R5");
        step(0, 0, 0, 4'h0, 0, K_BULK, 0, 0, "R5");
        step(0, 1, 1, D0, 0, 2'b11, 0, 0, "R2");
        step(0, 1, 1, D0, 0, 2'b11, 0, 0, "R5");
        step(0, 0, 0, 4'h0, 0, 2'b11, 0, 0, "R5");
        // R6 clear wins over packet
        step(0, 1, 1, D0, 0, K_BULK, 1, 0, "R6");
        step(0, 1, 1, D0, 0, K_BULK, 0, 0, "R6");
        step(0, 0, 0, 4'h0, 0, K_BULK, 1, 0, "R6");
        // R7 control setup
        step(0, 1, 1, D0, 0, K_CTRL, 0, 0, "R7");
        step(0, 0, 0, 4'h0, 1, K_CTRL, 0, 0, "R7");
        step(0, 1, 1, D1, 0, K_CTRL, 0, 0, "R7");
        step(0, 0, 0, 4'h0, 0, K_CTRL, 0, 0, "R7");
        step(0, 1, 1, D0, 0, K_CTRL, 0, 0, "R7");
        step(0, 1, 1, D1, 0, K_CTRL, 0, 0, "R7");
        // R8 status stage
        step(0, 0, 0, 4'h0, 0, K_CTRL, 0, 1, "R8");
        step(0, 1, 1, D0, 0, K_CTRL, 0, 1, "R8");
        step(0, 1, 1, D1, 0, K_CTRL, 0, 1, "R8");
        step(0, 0, 0, 4'h0, 1, K_CTRL, 0, 1, "R8");
        step(0, 1, 1, D0, 0, K_CTRL, 0, 1, "R8");
        // R9 isochronous
        step(0, 0, 0, 4'h0, 0, K_ISO, 1, 0, "R9");
        step(0, 1, 1, D1, 0, K_ISO, 0, 0, "R9");
        step(0, 1, 1, D0, 0, K_ISO, 0, 0, "R9");
        step(0, 1, 1, D0, 0, K_ISO, 0, 0, "R9");
        step(0, 1, 1, D1, 0, K_ISO, 0, 0, "R9");
        // R10 non-data PIDs
        step(0, 1, 1, D0, 0, K_BULK, 0, 0, "R10");
        step(0, 1, 1, 4'b0111, 0, K_BULK, 0, 0, "R10");
        step(0, 1, 1, 4'b1111, 0, K_BULK, 0, 0, "R10");
        step(0, 1, 1, 4'b1101, 0, K_BULK, 0, 0, "R10");
        // R11 control-only inputs on bulk
        step(0, 0, 0, 4'h0, 1, K_BULK, 0, 0, "R11");
        step(0, 0, 0, 4'h0, 0, K_BULK, 0, 1, "R11");
        step(0, 1, 1, D1, 1, K_BULK, 0, 1, "R11");
        // R1 reset mid-stream
        step(1, 1, 1, D0, 0, K_BULK, 0, 0, "R1");
        step(0, 0, 0, 4'h0, 0, K_BULK, 0, 0, "R1");
        @(posedge clk);
        #2;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule